// File: doc/BRIEF.md
# Sequence-Armed Watchdog Timer

This block is a register-mapped watchdog. A counter advances by one on every cycle in which a slow tick enable (nominally 32,768 Hz) is high. When the counter wraps past its all-ones value, the block raises a one-cycle reset request. It then refills the counter from a reload register and latches an event flag. Software chooses a timeout of N ticks by loading the two's-complement negative of N. For example, 20 s is -(20 × 32,768). The counter then climbs toward zero.

Software cannot start or stop the counter with a single write. It must write a two-word key to the arming register: 0x0000BBBB followed by 0x00004444 starts the counter, and 0x0000AAAA followed by 0x00005555 stops it. A write to the arming register is posted. It is held in a short delay line that models a synchronizer, and a status bit stays high until the word takes effect.

A soft-reset control returns every register to its reset value. A reset-done bit reports when the block is ready again. The block drives only the reset request; the system reset generator and any clock-domain crossing lie outside it.

Top module: `wdog_timer`

## Requirements
- R1: After the reset input, the counter (0x10) and reload (0x14) read 0, the block is stopped, the event flag (0x08 bit 0) and pending bit (0x18 bit 4) read 0, the arming register (0x1C) reads 0, and the ready bit (0x04 bit 0) reads 1.
- R2: When 0x0000BBBB is applied and then 0x00004444 is applied as the next applied word, the counter starts running.
- R3: When 0x0000AAAA is applied and then 0x00005555 is applied as the next applied word, the counter stops and holds its value.
- R4: If the word applied after a first key word is not its partner, the key is discarded, and that word is not taken as a new first word, so a later partner alone does nothing.
- R5: A write to 0x1C is accepted only when 0x18 bit 4 is 0. Accepting it sets that bit for exactly 2 cycles, and the word takes effect at the second clock edge after the write. A write made while the bit is 1 is dropped.
- R6: While the counter is running, it increments by one only in cycles where tick_en is high. While it is stopped, it keeps its value.
- R7: When the counter is running, tick_en is high, and the count is all ones, the counter loads the reload value. In that case reset_req is high for exactly the one following cycle and the event flag is set.
- R8: Writing 1 to bit 0 of 0x08 clears the event flag, and writing 0 leaves it unchanged. A wrap in the same cycle as the clear wins, so the flag stays set.
- R9: Writing 0x00 with bit 0 set performs a soft reset. Every register returns to its R1 value, the ready bit reads 0 for one cycle and then reads 1 again, and bit 0 itself reads 0. Bit 2 of 0x00 is a stored keep-awake bit.
- R10: Writes to 0x10, 0x14 and 0x0C (bit 0) are visible in the next cycle. A write to 0x10 takes priority over both counting and wrapping in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Slow count enable, one cycle wide per tick |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| reset_req | output | 1 | One-cycle reset request on counter wrap |

## Verification
A key sequencer left in the wrong state shows up at the ports. The counter starts or freezes where it should not, and the count readback diverges from the expected value on the first tick after the key's second word lands, two cycles after that word is written. A fault in the posting line moves the falling edge of the pending bit or lets a dropped write through, and both are visible within three cycles. A counter or reload fault is visible in the next readback. A wrap fault shows up one cycle after the all-ones count, as a missing, doubled or early reset_req pulse, or as a wrong reloaded value.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // Key sequencer state
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_HALT1  = 2'd1,
      SEQ_ARM1   = 2'd2
   } seq_state_e;

   // Register byte offsets
   localparam int unsigned OFF_CTRL   = 32'h00;
   localparam int unsigned OFF_READY  = 32'h04;
   localparam int unsigned OFF_EVENT  = 32'h08;
   localparam int unsigned OFF_EVTEN  = 32'h0C;
   localparam int unsigned OFF_COUNT  = 32'h10;
   localparam int unsigned OFF_RELOAD = 32'h14;
   localparam int unsigned OFF_POST   = 32'h18;
   localparam int unsigned OFF_ARM    = 32'h1C;

   localparam int unsigned POST_BIT   = 4;
   localparam int unsigned SRST_BIT   = 0;
   localparam int unsigned AWAKE_BIT  = 2;

endpackage

// File: rtl/wdog_post.sv
module wdog_post #(
   parameter int DW    = 32,
   parameter int DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] din,
   output logic          pending,
   output logic          apply,
   output logic [DW-1:0] dout
);

   logic [DEPTH-1:0] vld;
   logic [DW-1:0]    dat [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
         for (int i = 0; i < DEPTH; i++) dat[i] <= '0;
      end else if (flush) begin
         vld <= '0;
      end else begin
         vld[0] <= push;
         if (push) dat[0] <= din;
         for (int i = 1; i < DEPTH; i++) begin
            vld[i] <= vld[i-1];
            dat[i] <= dat[i-1];
         end
      end
   end

   assign pending = |vld;
   assign apply   = vld[DEPTH-1];
   assign dout    = dat[DEPTH-1];

endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
   import wdog_pkg::*;
#(
   parameter int          DW        = 32,
   parameter logic [31:0] KEY_ARM1  = 32'h0000_BBBB,
   parameter logic [31:0] KEY_ARM2  = 32'h0000_4444,
   parameter logic [31:0] KEY_HALT1 = 32'h0000_AAAA,
   parameter logic [31:0] KEY_HALT2 = 32'h0000_5555
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          apply,
   input  logic [DW-1:0] word,
   output logic          running
);

   seq_state_e state_q, state_d;
   logic       run_d;

   always_comb begin
      state_d = state_q;
      run_d   = running;
      if (apply) begin
         unique case (state_q)
            SEQ_ARM1: begin
               state_d = SEQ_IDLE;
               if (word == DW'(KEY_ARM2)) run_d = 1'b1;
            end
            SEQ_HALT1: begin
               state_d = SEQ_IDLE;
               if (word == DW'(KEY_HALT2)) run_d = 1'b0;
            end
            default: begin
               if (word == DW'(KEY_ARM1))       state_d = SEQ_ARM1;
               else if (word == DW'(KEY_HALT1)) state_d = SEQ_HALT1;
               else                             state_d = SEQ_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         running <= 1'b0;
      end else if (flush) begin
         state_q <= SEQ_IDLE;
         running <= 1'b0;
      end else begin
         state_q <= state_d;
         running <= run_d;
      end
   end

endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          run,
   input  logic          tick,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic [CW-1:0] reload,
   output logic [CW-1:0] count,
   output logic          wrap
);

   logic step;

   assign step = run && tick && !load;
   assign wrap = step && (count == {CW{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (flush)  count <= '0;
      else if (load)   count <= load_val;
      else if (wrap)   count <= reload;
      else if (step)   count <= count + 1'b1;
   end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
   import wdog_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          CNT_W      = 32,
   parameter int          POST_DEPTH = 2,
   parameter logic [31:0] KEY_ARM1   = 32'h0000_BBBB,
   parameter logic [31:0] KEY_ARM2   = 32'h0000_4444,
   parameter logic [31:0] KEY_HALT1  = 32'h0000_AAAA,
   parameter logic [31:0] KEY_HALT2  = 32'h0000_5555
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   input  logic              bus_we,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic              reset_req
);

   localparam int MIN_W = (POST_BIT > AWAKE_BIT ? POST_BIT : AWAKE_BIT) + 1;

   generate
      if (CNT_W < 16 || CNT_W < MIN_W) begin : g_bad_width
         $error("wdog_timer: CNT_W too narrow for keys and status fields");
      end
      if (POST_DEPTH < 1) begin : g_bad_depth
         $error("wdog_timer: POST_DEPTH must be at least 1");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("wdog_timer: ADDR_W cannot reach the register map");
      end
   endgenerate

   // Write decode
   logic wr_ctrl, wr_event, wr_evten, wr_count, wr_reload, wr_arm;
   logic srst, accept;

   assign wr_ctrl   = bus_we && (bus_addr == ADDR_W'(OFF_CTRL));
   assign wr_event  = bus_we && (bus_addr == ADDR_W'(OFF_EVENT));
   assign wr_evten  = bus_we && (bus_addr == ADDR_W'(OFF_EVTEN));
   assign wr_count  = bus_we && (bus_addr == ADDR_W'(OFF_COUNT));
   assign wr_reload = bus_we && (bus_addr == ADDR_W'(OFF_RELOAD));
   assign wr_arm    = bus_we && (bus_addr == ADDR_W'(OFF_ARM));
   assign srst      = wr_ctrl && bus_wdata[SRST_BIT];

   // Posting line and key sequencer
   logic             pending, apply, running, wrap;
   logic [CNT_W-1:0] post_word, count, reload_q;

   assign accept = wr_arm && !pending;

   wdog_post #(.DW(CNT_W), .DEPTH(POST_DEPTH)) u_post (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (srst),
      .push    (accept),
      .din     (bus_wdata),
      .pending (pending),
      .apply   (apply),
      .dout    (post_word)
   );

   wdog_seq #(
      .DW        (CNT_W),
      .KEY_ARM1  (KEY_ARM1),
      .KEY_ARM2  (KEY_ARM2),
      .KEY_HALT1 (KEY_HALT1),
      .KEY_HALT2 (KEY_HALT2)
   ) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (srst),
      .apply   (apply),
      .word    (post_word),
      .running (running)
   );

   wdog_count #(.CW(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (srst),
      .run      (running),
      .tick     (tick_en),
      .load     (wr_count),
      .load_val (bus_wdata),
      .reload   (reload_q),
      .count    (count),
      .wrap     (wrap)
   );

   // Control and status registers
   logic             awake_q, ready_q, flag_q, evten_q;
   logic [CNT_W-1:0] arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         awake_q   <= 1'b0;
         ready_q   <= 1'b1;
         flag_q    <= 1'b0;
         evten_q   <= 1'b0;
         reload_q  <= '0;
         arm_q     <= '0;
         reset_req <= 1'b0;
      end else if (srst) begin
         awake_q   <= 1'b0;
         ready_q   <= 1'b0;
         flag_q    <= 1'b0;
         evten_q   <= 1'b0;
         reload_q  <= '0;
         arm_q     <= '0;
         reset_req <= 1'b0;
      end else begin
         ready_q   <= 1'b1;
         reset_req <= wrap;
         if (wr_ctrl)   awake_q  <= bus_wdata[AWAKE_BIT];
         if (wr_evten)  evten_q  <= bus_wdata[0];
         if (wr_reload) reload_q <= bus_wdata;
         if (accept)    arm_q    <= bus_wdata;
         if (wrap)                          flag_q <= 1'b1;
         else if (wr_event && bus_wdata[0]) flag_q <= 1'b0;
      end
   end

   // Read mux
   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_W'(OFF_CTRL):   bus_rdata[AWAKE_BIT] = awake_q;
         ADDR_W'(OFF_READY):  bus_rdata[0]         = ready_q;
         ADDR_W'(OFF_EVENT):  bus_rdata[0]         = flag_q;
         ADDR_W'(OFF_EVTEN):  bus_rdata[0]         = evten_q;
         ADDR_W'(OFF_COUNT):  bus_rdata            = count;
         ADDR_W'(OFF_RELOAD): bus_rdata            = reload_q;
         ADDR_W'(OFF_POST):   bus_rdata[POST_BIT]  = pending;
         ADDR_W'(OFF_ARM):    bus_rdata            = arm_q;
         default:             bus_rdata            = '0;
      endcase
   end

endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
   parameter int CNT_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             srst,
   input logic             accept,
   input logic             pending,
   input logic             running,
   input logic             tick_en,
   input logic             count_ld,
   input logic [CNT_W-1:0] count,
   input logic             reset_req,
   input logic             flag,
   input logic             ready
);

   // R7: the request lasts one cycle
   assert_req_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);

   // R7: the request follows a running tick at all ones
   assert_req_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $past(running && tick_en && !count_ld && !srst
                          && (count == {CNT_W{1'b1}})));

   // R7: the event flag is up whenever the request is
   assert_req_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> flag);

   // R5: an accepted posted write shows as pending
   assert_post_pend_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !srst) |=> pending);

   // R5: no write is accepted while one is pending
   assert_post_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> !accept);

   // R6: a stopped counter with no software load holds
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !count_ld && !srst) |=> $stable(count));

   // R9: soft reset drops ready for one cycle
   assert_ready_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> !ready);
   assert_ready_back_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !srst) |=> ready);

endmodule

bind wdog_timer wdog_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .srst      (srst),
   .accept    (accept),
   .pending   (pending),
   .running   (running),
   .tick_en   (tick_en),
   .count_ld  (wr_count),
   .count     (count),
   .reset_req (reset_req),
   .flag      (flag_q),
   .ready     (ready_q)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   localparam logic [7:0] A_CTRL = 8'h00, A_READY = 8'h04, A_EVENT = 8'h08,
                          A_EVTEN = 8'h0C, A_COUNT = 8'h10, A_RELOAD = 8'h14,
                          A_POST = 8'h18, A_ARM = 8'h1C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic        reset_req;

   int n_cmp = 0;
   int n_bad = 0;
   bit ended = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdog_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_rdata (bus_rdata),
      .reset_req (reset_req)
   );

   // Behavioural reference state
   bit          m_run, m_flag, m_en, m_awake, m_ready, m_req;
   logic [31:0] m_cnt, m_rel, m_last, m_word;
   int          m_seq;   // 0 none, 1 halt key begun, 2 arm key begun
   int          m_left;  // cycles until the posted word lands

   task automatic m_clear();
      m_run = 0; m_flag = 0; m_en = 0; m_awake = 0; m_req = 0;
      m_cnt = 0; m_rel = 0; m_last = 0; m_word = 0; m_seq = 0; m_left = 0;
   endtask

   task automatic m_apply(input logic [31:0] w);
      if (m_seq == 2) begin
         if (w == 32'h4444) m_run = 1;
         m_seq = 0;
      end else if (m_seq == 1) begin
         if (w == 32'h5555) m_run = 0;
         m_seq = 0;
      end else if (w == 32'hBBBB) m_seq = 2;
      else if (w == 32'hAAAA) m_seq = 1;
      else m_seq = 0;
   endtask

   task automatic m_edge(input logic [7:0] a, input logic [31:0] d,
                         input bit w, input bit t);
      bit o_run, wrap;
      int o_left;
      logic [31:0] o_cnt;
      if (w && a == A_CTRL && d[0]) begin
         m_clear();
         m_ready = 0;
         return;
      end
      o_run = m_run; o_left = m_left; o_cnt = m_cnt;
      wrap = o_run && t && o_cnt == 32'hFFFF_FFFF && !(w && a == A_COUNT);
      m_req = wrap;
      m_ready = 1;
      if (wrap) m_flag = 1;
      else if (w && a == A_EVENT && d[0]) m_flag = 0;
      if (w && a == A_COUNT) m_cnt = d;
      else if (wrap) m_cnt = m_rel;
      else if (o_run && t) m_cnt = o_cnt + 1;
      if (w && a == A_RELOAD) m_rel = d;
      if (w && a == A_EVTEN) m_en = d[0];
      if (w && a == A_CTRL) m_awake = d[2];
      if (o_left > 0) begin
         m_left = o_left - 1;
         if (m_left == 0) m_apply(m_word);
      end
      if (w && a == A_ARM && o_left == 0) begin
         m_left = 2; m_word = d; m_last = d;
      end
   endtask

   function automatic logic [31:0] m_read(input logic [7:0] a);
      case (a)
         A_CTRL:   return {29'd0, m_awake, 2'b00};
         A_READY:  return {31'd0, m_ready};
         A_EVENT:  return {31'd0, m_flag};
         A_EVTEN:  return {31'd0, m_en};
         A_COUNT:  return m_cnt;
         A_RELOAD: return m_rel;
         A_POST:   return (m_left > 0) ? 32'h10 : 32'h0;
         A_ARM:    return m_last;
         default:  return 32'h0;
      endcase
   endfunction

   task automatic compare(input string tag);
      logic [31:0] exp_d;
      exp_d = m_read(bus_addr);
      n_cmp++;
      if (bus_rdata !== exp_d) begin
         n_bad++;
         $display("FAIL %s: rdata@%02h actual %08h expected %08h",
                  tag, bus_addr, bus_rdata, exp_d);
      end
      n_cmp++;
      if (reset_req !== m_req) begin
         n_bad++;
         $display("FAIL %s: reset_req actual %0b expected %0b",
                  tag, reset_req, m_req);
      end
   endtask

   // One clock: drive at the falling edge, model at the rising edge,
   // compare at the next falling edge.
   task automatic step(input logic [7:0] a, input logic [31:0] d,
                       input bit w, input bit t, input string tag);
      bus_addr = a; bus_wdata = d; bus_we = w; tick_en = t;
      @(posedge clk);
      m_edge(a, d, w, t);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
      step(a, d, 1'b1, 1'b1, tag);
   endtask

   task automatic idle(input logic [7:0] a, input int n, input string tag);
      for (int i = 0; i < n; i++) step(a, 32'h0, 1'b0, 1'b1, tag);
   endtask

   task automatic post(input logic [31:0] d, input string tag);
      wr(A_ARM, d, tag);
      idle(A_POST, 2, tag);
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      int cyc = 0;
      while (cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected fewer", cyc);
      finish_run();
   end

   initial begin
      m_clear();
      m_ready = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R1: reset values of every register
      idle(A_CTRL, 1, "R1"); idle(A_READY, 1, "R1"); idle(A_EVENT, 1, "R1");
      idle(A_COUNT, 1, "R1"); idle(A_RELOAD, 1, "R1"); idle(A_POST, 1, "R1");
      idle(A_ARM, 1, "R1");

      // R10: software writes land next cycle
      wr(A_RELOAD, 32'hFFFF_FFF8, "R10");
      idle(A_RELOAD, 1, "R10");
      wr(A_COUNT, 32'hFFFF_FFFA, "R10");
      wr(A_EVTEN, 32'h1, "R10");
      idle(A_EVTEN, 1, "R10");
      idle(A_COUNT, 3, "R6");   // stopped: holds

      // R5: a write while pending is dropped; R2: start key
      wr(A_ARM, 32'h0000_BBBB, "R5");
      step(A_ARM, 32'h0000_1234, 1'b1, 1'b1, "R5");
      idle(A_POST, 2, "R5");
      idle(A_ARM, 1, "R5");
      post(32'h0000_4444, "R2");

      // R7: run through two wraps
      idle(A_COUNT, 14, "R7");
      idle(A_EVENT, 1, "R7");

      // R8: write-one-to-clear, write zero keeps
      wr(A_EVENT, 32'h0, "R8");
      idle(A_EVENT, 1, "R8");
      wr(A_EVENT, 32'h1, "R8");
      idle(A_EVENT, 1, "R8");

      // R6: tick gating
      for (int i = 0; i < 10; i++) step(A_COUNT, 32'h0, 1'b0, (i % 3) == 0, "R6");

      // R10: count write beats a wrap
      wr(A_COUNT, 32'hFFFF_FFFF, "R10");
      wr(A_COUNT, 32'hFFFF_FFFE, "R10");
      idle(A_COUNT, 4, "R7");

      // R8: wrap and clear in the same cycle, flag stays
      wr(A_COUNT, 32'hFFFF_FFFF, "R8");
      wr(A_EVENT, 32'h1, "R8");
      idle(A_EVENT, 1, "R8");

      // R3: stop key, then count holds
      post(32'h0000_AAAA, "R3");
      post(32'h0000_5555, "R3");
      idle(A_COUNT, 5, "R3");

      // R4: wrong partner discards the key
      post(32'h0000_BBBB, "R4");
      post(32'h0000_1111, "R4");
      post(32'h0000_4444, "R4");
      idle(A_COUNT, 4, "R4");
      // R4: a first word of the other key is not a fresh start
      post(32'h0000_AAAA, "R4");
      post(32'h0000_BBBB, "R4");
      post(32'h0000_4444, "R4");
      idle(A_COUNT, 4, "R4");

      // R2: start again
      post(32'h0000_BBBB, "R2");
      post(32'h0000_4444, "R2");
      idle(A_COUNT, 4, "R2");

      // R9: keep-awake bit, then soft reset mid-post
      wr(A_CTRL, 32'h4, "R9");
      idle(A_CTRL, 1, "R9");
      wr(A_ARM, 32'h0000_AAAA, "R9");
      wr(A_CTRL, 32'h5, "R9");
      idle(A_READY, 2, "R9");
      idle(A_CTRL, 1, "R9"); idle(A_COUNT, 2, "R9"); idle(A_RELOAD, 1, "R9");
      idle(A_POST, 1, "R9"); idle(A_ARM, 1, "R9"); idle(A_EVTEN, 1, "R9");
      post(32'h0000_5555, "R9");
      idle(A_COUNT, 3, "R9");

      finish_run();
   end

endmodule